// File: doc/BRIEF.md
# Time-of-day alarm comparator with interrupt

This block holds a programmable alarm time (seconds, minutes and hours bytes) and compares it with the live BCD time counters of a real-time clock. It evaluates the comparison once per second, on the cycle that carries the 1 Hz tick. That is the cycle in which the counters already present the new second. When all three bytes are equal, an alarm event occurs.

An event always sets a sticky alarm status flag. The active-low interrupt pin is driven low only if the alarm-enable bit is 1 at the event. Software therefore clears the enable while it reloads the time counters, so that a transient match does not reach the processor. Re-enabling afterwards never raises a late interrupt from such a masked event. A status-register read strobe clears both the flag and the pin. An event in the same cycle as the read takes precedence.

The host loads the alarm bytes with a single-cycle write strobe, a slot select and a data byte. Writes are always accepted: there is no ready signal and no back-pressure. The counters, the serial bus and the register decode that produce these strobes lie outside this block.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset, irq_n is 1 and alarm_flag is 0. All three alarm bytes hold 8'hFF, which never equals a BCD time value, so no event occurs until the alarm bytes are written.
- R2: A cycle with wr_en=1 loads wr_data into the alarm byte chosen by wr_sel: 0 selects seconds, 1 selects minutes and 2 selects hours. wr_sel=3 changes no alarm byte.
- R3: An event occurs only in a cycle with tick_1hz=1. Equal values in cycles without the tick have no effect.
- R4: An event needs all 8 bits of all three bytes to be equal. This includes hours bit 7 (12/24 select) and bit 5 (AM/PM). A difference in any one bit of any byte prevents the event.
- R5: An event sets alarm_flag in the following cycle, whatever the value of alarm_en.
- R6: irq_n falls in the cycle after an event only if alarm_en was 1 at that event. Raising alarm_en later does not pull irq_n low. Once low, irq_n stays low while alarm_en is dropped, until a status read.
- R7: A cycle with stat_rd=1 and no event returns alarm_flag to 0 and irq_n to 1 in the next cycle.
- R8: When an event and stat_rd coincide, the event wins. alarm_flag is 1 afterwards, and irq_n is 0 if alarm_en was 1.
- R9: A write in the same cycle as a tick does not take part in that cycle's comparison: the comparison uses the alarm byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse per second; the counters already hold the new time |
| cur_sec | input | 8 | Live BCD seconds |
| cur_min | input | 8 | Live BCD minutes |
| cur_hr | input | 8 | Live hours byte, with BCD hour, 12/24 bit 7 and AM/PM bit 5 |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 2 | Alarm byte select: 0 seconds, 1 minutes, 2 hours, 3 none |
| wr_data | input | 8 | Alarm byte write data |
| alarm_en | input | 1 | Alarm interrupt enable from the interrupt control register |
| stat_rd | input | 1 | Status register read strobe; clears flag and interrupt |
| irq_n | output | 1 | Alarm interrupt, active low |
| alarm_flag | output | 1 | Sticky alarm status bit |

## Verification
A wrong alarm byte only becomes visible at the next tick whose time should have matched. It shows up there as a missing or extra rise of alarm_flag, one cycle after that tick. A wrong flag or interrupt register is visible in the cycle after the event or read that should have moved it. Where the two outputs disagree (irq_n low while the flag is clear, or irq_n low after a masked event), the fault shows at once.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SLOTS  = 3;

  typedef enum logic [1:0] {
    SLOT_SEC  = 2'd0,
    SLOT_MIN  = 2'd1,
    SLOT_HR   = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;
endpackage

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank #(
  parameter int unsigned W       = 8,
  parameter int unsigned NSLOT   = 3,
  parameter int unsigned SEL_W   = 2,
  parameter logic [W-1:0] INIT_V = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [W-1:0]              wr_data,
  output logic [NSLOT-1:0][W-1:0]   latch_q
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   latch_q[s] <= INIT_V;
      else if (hit) latch_q[s] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int unsigned W     = 8,
  parameter int unsigned NSLOT = 3
) (
  input  logic                    tick,
  input  logic [NSLOT-1:0][W-1:0] alarm_v,
  input  logic [NSLOT-1:0][W-1:0] time_v,
  output logic                    match_evt
);
  logic [NSLOT-1:0] eq;
  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    assign eq[s] = (alarm_v[s] == time_v[s]);
  end
  assign match_evt = tick && (&eq);
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic match_evt,
  input  logic enable,
  input  logic rd_clr,
  output logic flag_q,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (match_evt)   flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;

      if (match_evt && enable) irq_q <= 1'b1;
      else if (rd_clr)         irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_pkg::*;
#(
  parameter int unsigned W     = BYTE_W,
  parameter int unsigned NSLOT = SLOTS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_1hz,
  input  logic [W-1:0] cur_sec,
  input  logic [W-1:0] cur_min,
  input  logic [W-1:0] cur_hr,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         alarm_en,
  input  logic         stat_rd,
  output logic         irq_n,
  output logic         alarm_flag
);
  localparam int unsigned SEL_W = $bits(slot_e);

  logic [NSLOT-1:0][W-1:0] latch_q;
  logic [NSLOT-1:0][W-1:0] now_v;
  logic                    match_evt;
  logic                    irq_q;

  assign now_v = {cur_hr, cur_min, cur_sec};

  alarm_latch_bank #(.W(W), .NSLOT(NSLOT), .SEL_W(SEL_W), .INIT_V('1)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .latch_q (latch_q)
  );

  alarm_match #(.W(W), .NSLOT(NSLOT)) u_match (
    .tick      (tick_1hz),
    .alarm_v   (latch_q),
    .time_v    (now_v),
    .match_evt (match_evt)
  );

  alarm_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_evt (match_evt),
    .enable    (alarm_en),
    .rd_clr    (stat_rd),
    .flag_q    (alarm_flag),
    .irq_q     (irq_q)
  );

  assign irq_n = ~irq_q;
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned NSLOT = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_1hz,
  input logic                    wr_en,
  input logic [1:0]              wr_sel,
  input logic [W-1:0]            wr_data,
  input logic                    alarm_en,
  input logic                    stat_rd,
  input logic                    irq_n,
  input logic                    alarm_flag,
  input logic                    match_evt,
  input logic [NSLOT-1:0][W-1:0] latch_q
);
  // R2: the seconds byte takes the written data
  assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (latch_q[0] == $past(wr_data)));

  // R2: the hours byte takes the written data
  assert_hr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (latch_q[2] == $past(wr_data)));

  // R3: the flag only rises after a tick
  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick_1hz));

  // R5: an event sets the flag
  assert_evt_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> alarm_flag);

  // R6: the interrupt falls only after an enabled event
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(match_evt && alarm_en));

  // R6: the interrupt is never low without the flag
  assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> alarm_flag);

  // R7: a read without an event clears both outputs
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !match_evt) |=> (!alarm_flag && irq_n));
endmodule

bind alarm_cmp_top alarm_cmp_chk #(.W(W), .NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_1hz   (tick_1hz),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .alarm_en   (alarm_en),
  .stat_rd    (stat_rd),
  .irq_n      (irq_n),
  .alarm_flag (alarm_flag),
  .match_evt  (match_evt),
  .latch_q    (latch_q)
);

// File: tb/alarm_cmp_top_test.sv
module alarm_cmp_top_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       alarm_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic       irq_n;
  logic       alarm_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_cmp_top uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .alarm_en(alarm_en), .stat_rd(stat_rd),
    .irq_n(irq_n), .alarm_flag(alarm_flag)
  );

  task automatic expect_out(string req, logic exp_flag, logic exp_irq_n);
    n_chk++;
    if (alarm_flag !== exp_flag || irq_n !== exp_irq_n) begin
      n_bad++;
      $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b",
               req, alarm_flag, irq_n, exp_flag, exp_irq_n);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_at(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic rd);
    cur_sec = s; cur_min = m; cur_hr = h;
    tick_1hz = 1'b1; stat_rd = rd;
    @(negedge clk);
    tick_1hz = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic do_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    wr(2'd0, s); wr(2'd1, m); wr(2'd2, h);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 1'b0, 1'b1);
    tick_at(8'h00, 8'h00, 8'h00, 1'b0);
    expect_out("R1 no event before programming", 1'b0, 1'b1);
  endtask

  task automatic t_basic();
    alarm_en = 1'b1;
    set_alarm(8'h30, 8'h15, 8'h08);
    tick_at(8'h30, 8'h15, 8'h08, 1'b0);
    expect_out("R2 R5 R6 enabled event", 1'b1, 1'b0);
    do_read();
    expect_out("R7 read clears", 1'b0, 1'b1);
  endtask

  task automatic t_no_tick();
    cur_sec = 8'h30; cur_min = 8'h15; cur_hr = 8'h08;
    repeat (3) @(negedge clk);
    expect_out("R3 equal time without tick", 1'b0, 1'b1);
  endtask

  task automatic t_partial();
    tick_at(8'h30, 8'h15, 8'h88, 1'b0);
    expect_out("R4 hours bit7 differs", 1'b0, 1'b1);
    tick_at(8'h30, 8'h15, 8'h28, 1'b0);
    expect_out("R4 hours bit5 differs", 1'b0, 1'b1);
    tick_at(8'h31, 8'h15, 8'h08, 1'b0);
    expect_out("R4 seconds differ", 1'b0, 1'b1);
    tick_at(8'h30, 8'h16, 8'h08, 1'b0);
    expect_out("R4 minutes differ", 1'b0, 1'b1);
  endtask

  task automatic t_mask();
    alarm_en = 1'b0;
    tick_at(8'h30, 8'h15, 8'h08, 1'b0);
    expect_out("R5 masked event sets flag only", 1'b1, 1'b1);
    alarm_en = 1'b1;
    @(negedge clk);
    expect_out("R6 late enable raises no interrupt", 1'b1, 1'b1);
    do_read();
    expect_out("R7 read after masked event", 1'b0, 1'b1);
  endtask

  task automatic t_hold();
    alarm_en = 1'b1;
    tick_at(8'h30, 8'h15, 8'h08, 1'b0);
    alarm_en = 1'b0;
    repeat (2) @(negedge clk);
    expect_out("R6 interrupt held with enable dropped", 1'b1, 1'b0);
    do_read();
    expect_out("R7 read releases interrupt", 1'b0, 1'b1);
    alarm_en = 1'b1;
  endtask

  task automatic t_collide();
    tick_at(8'h30, 8'h15, 8'h08, 1'b0);
    tick_at(8'h30, 8'h15, 8'h08, 1'b1);
    expect_out("R8 event wins over read", 1'b1, 1'b0);
    do_read();
    expect_out("R8 later read clears", 1'b0, 1'b1);
  endtask

  task automatic t_write_on_tick();
    cur_sec = 8'h30; cur_min = 8'h15; cur_hr = 8'h08;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h45; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    expect_out("R9 compare uses old byte", 1'b1, 1'b0);
    do_read();
    tick_at(8'h45, 8'h15, 8'h08, 1'b0);
    expect_out("R9 new byte active next tick", 1'b1, 1'b0);
    do_read();
  endtask

  task automatic t_bad_sel();
    wr(2'd3, 8'h00);
    tick_at(8'h45, 8'h15, 8'h08, 1'b0);
    expect_out("R2 select 3 leaves bytes unchanged", 1'b1, 1'b0);
    do_read();
    expect_out("R2 cleanup", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_tick();
    t_partial();
    t_mask();
    t_hold();
    t_collide();
    t_write_on_tick();
    t_bad_sel();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule